// File: doc/BRIEF.md
# Single-Bit Operation and Carry-Logic Unit

This block performs one-bit operations for a small CPU datapath. Each request presents a 16-bit operand word, a 4-bit bit index, an operation code, the current carry (C) and zero (Z) flags, and a condition result that upstream logic has already evaluated. One clock later the block returns the modified word, a write-back enable and the updated C and Z flags.

The operation set covers several groups:

- **Bit writes:** set, clear and invert of the selected bit, plus a conditional store that writes the condition result into the bit.
- **Bit tests:** a plain test and a negated test, each of which reports the bit through the flags. Test-and-set and test-and-clear report the bit the same way and then modify it.
- **Carry logic:** the carry flag works as a one-bit accumulator. It can be combined with the selected bit, or with its inverse, by AND, OR or XOR.

Address generation, memory access and condition decoding all sit outside the block.

A two-state controller tracks whether the output register holds a fresh result. `ST_EMPTY` goes to `ST_FULL` when `in_valid` is high, and stays in `ST_EMPTY` otherwise. `ST_FULL` stays in `ST_FULL` while `in_valid` stays high, and returns to `ST_EMPTY` when it drops. The output register loads only on cycles where `in_valid` is high.

Top module: `bitop_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low in the cycle after each cycle with `in_valid` low. Results appear with that same one-cycle latency.
- R2: Opcode 0 sets the selected bit to 1, opcode 1 clears it to 0, and opcode 2 complements it.
- R3: Opcode 7 (conditional store) writes `cond_true` into the selected bit.
- R4: Opcodes 0, 1, 2 and 7 leave every unselected bit unchanged, and pass C and Z through unchanged.
- R5: Opcodes 8, 9 and 10 set C to C AND bit, C OR bit and C XOR bit respectively. Z and the word are unchanged.
- R6: Opcodes 11, 12 and 13 set C to C AND NOT bit, C OR NOT bit and C XOR NOT bit respectively. Z and the word are unchanged.
- R7: Opcode 3 (test) sets Z to NOT bit and C to bit, and leaves the word unchanged.
- R8: Opcode 4 (negated test) sets both Z and C to NOT bit, and leaves the word unchanged.
- R9: Opcodes 5 (test-and-set) and 6 (test-and-clear) set Z to NOT bit and C to bit, using the bit value before the write. They then write 1 or 0 respectively into that bit.
- R10: `wr_en` is 1 exactly for opcodes 0, 1, 2, 5, 6 and 7.
- R11: Opcodes 14 and 15 are no-ops. The word, C and Z pass through unchanged and `wr_en` is 0.
- R12: While reset is asserted, `out_valid`, `wr_en`, `result`, `c_out` and `z_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation code |
| operand | input | 16 | Word to test or modify |
| bit_idx | input | 4 | Index of the selected bit |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| cond_true | input | 1 | Evaluated condition for conditional store |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 16 | Word after the operation |
| wr_en | output | 1 | The word must be written back |
| c_out | output | 1 | Updated carry flag |
| z_out | output | 1 | Updated zero flag |

## Verification
Every result is registered once, so the word, `wr_en`, C, Z and `out_valid` all belong to the clock edge that follows the request. The bench drives each request on a falling edge and compares the outputs on the next falling edge, half a period after they were registered. It sweeps every opcode, every bit index, all eight combinations of C, Z and condition, and three operand patterns. It also drops `in_valid` for a cycle to confirm that the strobe falls one edge later.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_SET    = 4'd0,
        OP_CLR    = 4'd1,
        OP_INV    = 4'd2,
        OP_TST    = 4'd3,
        OP_NTST   = 4'd4,
        OP_TSTSET = 4'd5,
        OP_TSTCLR = 4'd6,
        OP_CSTORE = 4'd7,
        OP_CAND   = 4'd8,
        OP_COR    = 4'd9,
        OP_CXOR   = 4'd10,
        OP_CNAND  = 4'd11,
        OP_CNOR   = 4'd12,
        OP_CXNOR  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } bitop_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/bit_select.sv
module bit_select #(
    parameter int WIDTH = 16,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    input  logic [IDXW-1:0]  idx,
    output logic [WIDTH-1:0] mask,
    output logic             picked
);
    // One-hot mask of the selected position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        assign mask[i] = (idx == IDXW'(i));
    end

    assign picked = |(word & mask);
endmodule

// File: rtl/bit_alu.sv
module bit_alu
    import bitop_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  bitop_op_e        op,
    input  logic [WIDTH-1:0] word,
    input  logic [WIDTH-1:0] mask,
    input  logic             picked,
    input  logic             c_in,
    input  logic             z_in,
    input  logic             cond_true,
    output logic [WIDTH-1:0] word_nx,
    output logic             wr_nx,
    output logic             c_nx,
    output logic             z_nx
);
    always_comb begin
        word_nx = word;
        wr_nx   = 1'b0;
        c_nx    = c_in;
        z_nx    = z_in;
        unique case (op)
            OP_SET: begin
                word_nx = word | mask;
                wr_nx   = 1'b1;
            end
            OP_CLR: begin
                word_nx = word & ~mask;
                wr_nx   = 1'b1;
            end
            OP_INV: begin
                word_nx = word ^ mask;
                wr_nx   = 1'b1;
            end
            OP_CSTORE: begin
                word_nx = cond_true ? (word | mask) : (word & ~mask);
                wr_nx   = 1'b1;
            end
            OP_TST: begin
                z_nx = ~picked;
                c_nx = picked;
            end
            OP_NTST: begin
                z_nx = ~picked;
                c_nx = ~picked;
            end
            OP_TSTSET: begin
                z_nx    = ~picked;
                c_nx    = picked;
                word_nx = word | mask;
                wr_nx   = 1'b1;
            end
            OP_TSTCLR: begin
                z_nx    = ~picked;
                c_nx    = picked;
                word_nx = word & ~mask;
                wr_nx   = 1'b1;
            end
            OP_CAND:  c_nx = c_in & picked;
            OP_COR:   c_nx = c_in | picked;
            OP_CXOR:  c_nx = c_in ^ picked;
            OP_CNAND: c_nx = c_in & ~picked;
            OP_CNOR:  c_nx = c_in | ~picked;
            OP_CXNOR: c_nx = c_in ^ ~picked;
            OP_RSV14, OP_RSV15: begin
                word_nx = word;
            end
            default: begin
                word_nx = word;
            end
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] operand,
    input  logic [IDXW-1:0]  bit_idx,
    input  logic             c_in,
    input  logic             z_in,
    input  logic             cond_true,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             c_out,
    output logic             z_out
);
    out_state_e       state_q, state_d;
    bitop_op_e        op;
    logic [WIDTH-1:0] mask;
    logic             picked;
    logic [WIDTH-1:0] word_nx;
    logic             wr_nx, c_nx, z_nx;

    assign op = bitop_op_e'(opcode);

    bit_select #(.WIDTH(WIDTH)) u_sel (
        .word   (operand),
        .idx    (bit_idx),
        .mask   (mask),
        .picked (picked)
    );

    bit_alu #(.WIDTH(WIDTH)) u_alu (
        .op        (op),
        .word      (operand),
        .mask      (mask),
        .picked    (picked),
        .c_in      (c_in),
        .z_in      (z_in),
        .cond_true (cond_true),
        .word_nx   (word_nx),
        .wr_nx     (wr_nx),
        .c_nx      (c_nx),
        .z_nx      (z_nx)
    );

    // Next-state logic of the output controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output register: loads only on accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
            c_out  <= 1'b0;
            z_out  <= 1'b0;
        end else if (in_valid) begin
            result <= word_nx;
            wr_en  <= wr_nx;
            c_out  <= c_nx;
            z_out  <= z_nx;
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
    import bitop_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDXW = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       opcode,
    input logic [WIDTH-1:0] operand,
    input logic [IDXW-1:0]  bit_idx,
    input logic             c_in,
    input logic             z_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic             c_out,
    input logic             z_out
);
    logic is_write_op, is_flagless_write, is_readonly;
    assign is_write_op = (opcode <= 4'd2) || (opcode >= 4'd5 && opcode <= 4'd7);
    assign is_flagless_write = (opcode <= 4'd2) || (opcode == 4'd7);
    assign is_readonly = !is_write_op;

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_other_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((result ^ $past(operand)) &
                      ~(WIDTH'(1) << $past(bit_idx))) == '0);
    p_flags_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_flagless_write) |=>
            (c_out == $past(c_in) && z_out == $past(z_in)));
    p_readonly_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_readonly) |=> (!wr_en && result == $past(operand)));
    p_write_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_write_op) |=> wr_en);
    p_test_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd3) |=> (z_out != c_out));
    p_ntest_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd4) |=> (z_out == c_out));
endmodule

bind bitop_unit bitop_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .operand   (operand),
    .bit_idx   (bit_idx),
    .c_in      (c_in),
    .z_in      (z_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .c_out     (c_out),
    .z_out     (z_out)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  opcode;
    logic [15:0] operand;
    logic [3:0]  bit_idx;
    logic        c_in, z_in, cond_true;
    logic        out_valid;
    logic [15:0] result;
    logic        wr_en, c_out, z_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bitop_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .operand(operand), .bit_idx(bit_idx), .c_in(c_in), .z_in(z_in),
        .cond_true(cond_true), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .c_out(c_out), .z_out(z_out)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2:    return "R2";
            4'd3:                return "R7";
            4'd4:                return "R8";
            4'd5, 4'd6:          return "R9";
            4'd7:                return "R3";
            4'd8, 4'd9, 4'd10:   return "R5";
            4'd11, 4'd12, 4'd13: return "R6";
            default:             return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] pats [3];
        pats[0] = 16'h0000;
        pats[1] = 16'hFFFF;
        pats[2] = 16'hA5C3;
        rst_n = 1'b0; in_valid = 1'b0; opcode = '0; operand = '0;
        bit_idx = '0; c_in = 1'b0; z_in = 1'b0; cond_true = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {11'd0, out_valid, wr_en, c_out, z_out, result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check("R1", {31'd0, out_valid}, 32'd0);

        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 16; o++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int f = 0; f < 8; f++) begin
                        logic [15:0] ew;
                        logic ec, ez, ewr, bit_v;
                        opcode = 4'(o); operand = pats[p]; bit_idx = 4'(b);
                        c_in = f[0]; z_in = f[1]; cond_true = f[2];
                        in_valid = 1'b1;
                        bit_v = (pats[p] >> b) & 16'd1;
                        ew = pats[p]; ec = f[0]; ez = f[1]; ewr = 1'b0;
                        case (o)
                            0: begin ew[b] = 1'b1; ewr = 1'b1; end
                            1: begin ew[b] = 1'b0; ewr = 1'b1; end
                            2: begin ew[b] = !bit_v; ewr = 1'b1; end
                            3: begin ez = !bit_v; ec = bit_v; end
                            4: begin ez = !bit_v; ec = !bit_v; end
                            5: begin ez = !bit_v; ec = bit_v; ew[b] = 1'b1; ewr = 1'b1; end
                            6: begin ez = !bit_v; ec = bit_v; ew[b] = 1'b0; ewr = 1'b1; end
                            7: begin ew[b] = f[2]; ewr = 1'b1; end
                            8: ec = f[0] && bit_v;
                            9: ec = f[0] || bit_v;
                            10: ec = f[0] != bit_v;
                            11: ec = f[0] && !bit_v;
                            12: ec = f[0] || !bit_v;
                            13: ec = f[0] == bit_v;
                            default: ;
                        endcase
                        @(negedge clk);
                        // R1 strobe, R4 flag pass-through, R10 enable
                        check({req_of(4'(o)), "/R1/R4/R10"},
                              {12'd0, out_valid, wr_en, c_out, z_out, result},
                              {12'd0, 1'b1, ewr, ec, ez, ew});
                    end
                end
            end
            // R1: strobe falls one cycle after in_valid drops
            in_valid = 1'b0;
            @(negedge clk);
            check("R1", {31'd0, out_valid}, 32'd0);
        end
        done = 1'b1;
        finish_run();
    end
endmodule